// File: doc/BRIEF.md
# Multichannel 4B5B Audio Link Framer

This block gathers one sample period's worth of audio subframes, up to 56 channels, and sends them over one serial link as a steady stream of 5-bit line symbols, one symbol per clock. A downstream serialiser shifts the symbols out, so the link runs at a fixed symbol rate whatever the audio sample rate is. Four data bits become five line bits.

A frame-start strobe latches every channel's 28-bit payload (audio plus the validity, user, status and parity bits) together with its active flag. Each channel then becomes a 32-bit subframe. The four low bits, which would otherwise hold a line preamble, carry mode flags instead. The subframe is cut into eight nibbles, and each nibble is mapped through the 4B5B data table. A two-symbol sync pair goes out ahead of every frame and fills every slot in which no frame data is waiting. A strobe that arrives while an earlier frame is still pending or being sent is discarded and raises a sticky overrun flag.

Top module: `mch_link_framer`

## Requirements
- R1: While reset is asserted, `sym` is 10001 and `overrun` is 0. After reset, with no frame pending, the output alternates 11000, 10001, 11000, ... starting with 11000.
- R2: Each data nibble is sent as its 4B5B code: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101. The sync pair is 11000 followed by 10001, and only these 18 values ever appear on `sym`.
- R3: The subframe of channel c is {payload[27:0], mode[3:0]}, with the mode nibble in bits 3:0. It is sent as eight symbols, least significant nibble first. The payload of channel c is `chPayload[c*28 +: 28]`.
- R4: Mode bit 0 is 1 only for channel 0. Bit 1 is the channel's active flag. Bit 2 is 1 for odd channel indices (second member of a pair) and 0 for even ones. Bit 3 is the `blockStart` value latched with the frame, set in every subframe of that frame.
- R5: An inactive channel is still sent in its slot, with mode bit 1 cleared and all 28 payload bits sent as zero.
- R6: The data of a frame is NUM_CH*8 consecutive data symbols with no sync symbol between them, in ascending channel order from channel 0. No data symbol appears without an accepted frame.
- R7: The first data symbol of every frame comes immediately after a 10001 symbol that completes a sync pair.
- R8: A 11000 symbol is always followed directly by 10001.
- R9: A `frameStart` pulse that arrives while a frame is pending or still being sent is dropped and sets `overrun`, which then stays at 1 until reset. Later frames are still accepted.
- R10: The frame that is sent is the data present at the accepting strobe. Input changes after that strobe do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle strobe that starts a frame |
| blockStart | input | 1 | Block flag, latched with the frame |
| chActive | input | NUM_CH | Per-channel on/off flag |
| chPayload | input | NUM_CH*28 | Per-channel payload bits 4..31 of the subframe |
| sym | output | 5 | Line symbol for the current clock |
| overrun | output | 1 | Sticky flag for a dropped frame strobe |

## Verification
The hardest case to reach is a strobe that lands while the previous frame is still in the pipe, either waiting for its sync pair or part-way through its symbols. The bench sends a second strobe a few cycles after an accepted one. It then checks that no extra data symbols appear, that the flag stays set, and that a later frame still goes through. Right after each accepted strobe the bench inverts every input, so any path that reads live inputs instead of the latched copy shows up as a symbol mismatch.

// File: rtl/mch_link_framer_pkg.sv
package mch_link_framer_pkg;
  localparam int SUB_W     = 32;
  localparam int MODE_W    = 4;
  localparam int PAY_W     = SUB_W - MODE_W;
  localparam int NIB_W     = 4;
  localparam int SYM_W     = 5;
  localparam int NIBS      = SUB_W / NIB_W;
  localparam int NIB_IDX_W = $clog2(NIBS);

  localparam logic [SYM_W-1:0] SYNC_J = 5'b11000;
  localparam logic [SYM_W-1:0] SYNC_K = 5'b10001;

  typedef enum logic [1:0] {SEL_J, SEL_K, SEL_DATA} symSel_e;

  typedef struct packed {
    logic                 capture;
    symSel_e              sel;
    logic [NIB_IDX_W-1:0] nib;
  } ctrlStrobe_t;

  function automatic logic [SYM_W-1:0] encNibble(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: return 5'b11110;
      4'h1: return 5'b01001;
      4'h2: return 5'b10100;
      4'h3: return 5'b10101;
      4'h4: return 5'b01010;
      4'h5: return 5'b01011;
      4'h6: return 5'b01110;
      4'h7: return 5'b01111;
      4'h8: return 5'b10010;
      4'h9: return 5'b10011;
      4'hA: return 5'b10110;
      4'hB: return 5'b10111;
      4'hC: return 5'b11010;
      4'hD: return 5'b11011;
      4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  function automatic logic isLineSym(input logic [SYM_W-1:0] s);
    if (s == SYNC_J || s == SYNC_K) return 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (encNibble(NIB_W'(i)) == s) return 1'b1;
    end
    return 1'b0;
  endfunction
endpackage

// File: rtl/mch_link_framer_ctrl.sv
module mch_link_framer_ctrl
  import mch_link_framer_pkg::*;
#(
  parameter int NUM_CH = 56,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameStart,
  output ctrlStrobe_t     strobe,
  output logic [CH_W-1:0] chIdx,
  output logic            overrun
);
  typedef enum logic [1:0] {ST_J, ST_K, ST_DATA} state_e;

  state_e               state;
  logic                 pending;
  logic [NIB_IDX_W-1:0] nib;
  logic                 busy;
  logic                 lastNib;
  logic                 lastCh;

  always_comb begin
    busy           = pending || (state == ST_DATA);
    lastNib        = (nib == NIB_IDX_W'(NIBS - 1));
    lastCh         = (chIdx == CH_W'(NUM_CH - 1));
    strobe.capture = frameStart && !busy;
    strobe.nib     = nib;
    case (state)
      ST_J:    strobe.sel = SEL_J;
      ST_K:    strobe.sel = SEL_K;
      default: strobe.sel = SEL_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_J;
      pending <= 1'b0;
      nib     <= '0;
      chIdx   <= '0;
      overrun <= 1'b0;
    end else begin
      if (frameStart && busy) overrun <= 1'b1;
      if (strobe.capture)     pending <= 1'b1;
      case (state)
        ST_J: state <= ST_K;
        ST_K: begin
          if (pending) begin
            state   <= ST_DATA;
            pending <= 1'b0;
            nib     <= '0;
            chIdx   <= '0;
          end else begin
            state <= ST_J;
          end
        end
        ST_DATA: begin
          nib <= nib + 1'b1;
          if (lastNib) begin
            nib <= '0;
            if (lastCh) state <= ST_J;
            else        chIdx <= chIdx + 1'b1;
          end
        end
        default: state <= ST_J;
      endcase
    end
  end

  AST_SYNC_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_J |=> state == ST_K); // R8
  AST_FRAME_AFTER_K: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && $past(state) != ST_DATA) |-> $past(state) == ST_K); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun); // R9
  AST_DROP_IN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && state == ST_DATA) |=> overrun); // R9
  AST_CH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    chIdx <= CH_W'(NUM_CH - 1)); // R6
endmodule

// File: rtl/mch_link_framer_dp.sv
module mch_link_framer_dp
  import mch_link_framer_pkg::*;
#(
  parameter int NUM_CH = 56,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [CH_W-1:0]         chIdx,
  input  logic                    blockStart,
  input  logic [NUM_CH-1:0]       chActive,
  input  logic [NUM_CH*PAY_W-1:0] chPayload,
  output logic [SYM_W-1:0]        sym
);
  logic [PAY_W-1:0]  payBuf [NUM_CH];
  logic [NUM_CH-1:0] actBuf;
  logic              blkBuf;
  logic              selAct;
  logic [MODE_W-1:0] modeBits;
  logic [SUB_W-1:0]  subWord;
  logic [NIB_W-1:0]  curNib;

  for (genvar g = 0; g < NUM_CH; g++) begin : gLatch
    always_ff @(posedge clk) begin
      if (strobe.capture) begin
        payBuf[g] <= chPayload[g*PAY_W +: PAY_W];
        actBuf[g] <= chActive[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) blkBuf <= blockStart;
  end

  always_comb begin
    selAct   = actBuf[chIdx];
    modeBits = {blkBuf, chIdx[0], selAct, (chIdx == '0)};
    subWord  = {(selAct ? payBuf[chIdx] : {PAY_W{1'b0}}), modeBits};
    curNib   = subWord[strobe.nib*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sym <= SYNC_K;
    end else begin
      case (strobe.sel)
        SEL_J:   sym <= SYNC_J;
        SEL_K:   sym <= SYNC_K;
        default: sym <= encNibble(curNib);
      endcase
    end
  end

  AST_SYM_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    isLineSym(sym)); // R2
  AST_J_THEN_K: assert property (@(posedge clk) disable iff (!rstN)
    sym == SYNC_J |=> sym == SYNC_K); // R8
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(blkBuf) && $stable(actBuf)); // R10
endmodule

// File: rtl/mch_link_framer.sv
module mch_link_framer
  import mch_link_framer_pkg::*;
#(
  parameter int NUM_CH = 56
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameStart,
  input  logic                    blockStart,
  input  logic [NUM_CH-1:0]       chActive,
  input  logic [NUM_CH*PAY_W-1:0] chPayload,
  output logic [SYM_W-1:0]        sym,
  output logic                    overrun
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  ctrlStrobe_t     strobe;
  logic [CH_W-1:0] chIdx;

  mch_link_framer_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .strobe(strobe), .chIdx(chIdx), .overrun(overrun)
  );

  mch_link_framer_dp #(.NUM_CH(NUM_CH), .CH_W(CH_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chIdx(chIdx),
    .blockStart(blockStart), .chActive(chActive), .chPayload(chPayload),
    .sym(sym)
  );
endmodule

// File: tb/tb_mch_link_framer.sv
module tb_mch_link_framer;
  localparam int NCH  = 4;
  localparam int PW   = 28;
  localparam int FSYM = NCH * 8;
  localparam logic [4:0] SJ = 5'b11000;
  localparam logic [4:0] SK = 5'b10001;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              frameStart = 1'b0;
  logic              blockStart = 1'b0;
  logic [NCH-1:0]    chActive = '0;
  logic [NCH*PW-1:0] chPayload = '0;
  logic [4:0]        sym;
  logic              overrun;

  logic [4:0] expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  mch_link_framer #(.NUM_CH(NCH)) dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .blockStart(blockStart),
    .chActive(chActive), .chPayload(chPayload), .sym(sym), .overrun(overrun)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] code(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                           5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  // Driver: pushes expected data symbols for an accepted frame (R3, R4, R5)
  task automatic sendFrame(input bit blk, input logic [NCH-1:0] act,
                           input logic [NCH*PW-1:0] pay, input bit accepted);
    logic [31:0] w;
    @(negedge clk);
    blockStart = blk; chActive = act; chPayload = pay; frameStart = 1'b1;
    if (accepted) begin
      for (int ch = 0; ch < NCH; ch++) begin
        w = {(act[ch] ? pay[ch*PW +: PW] : {PW{1'b0}}), blk, 1'(ch & 1), act[ch], (ch == 0)};
        for (int n = 0; n < 8; n++) expQ.push_back(code(w[n*4 +: 4]));
      end
    end
    @(negedge clk);
    frameStart = 1'b0;
    // R10: disturb every input right after the strobe
    chPayload = ~pay; chActive = ~act; blockStart = ~blk;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [NCH*PW-1:0] rndPay();
    logic [NCH*PW-1:0] p;
    for (int ch = 0; ch < NCH; ch++) p[ch*PW +: PW] = PW'($urandom);
    return p;
  endfunction

  // Monitor / scoreboard
  initial begin
    logic [4:0] prev;
    logic [4:0] s;
    logic [4:0] e;
    int frameCnt;
    prev = SK;
    frameCnt = 0;
    wait (rstN);
    forever begin
      @(negedge clk);
      s = sym;
      if (prev == SJ) chk(s == SK, "R8 sync J not followed by K", 32'(s), 32'(SK));
      if (s == SJ || s == SK) begin
        if (frameCnt != 0) chk(1'b0, "R6 sync symbol inside frame", 32'(s), 32'h0);
      end else begin
        if (frameCnt == 0) chk(prev == SK, "R7 frame not preceded by K", 32'(prev), 32'(SK));
        if (expQ.size() == 0) begin
          chk(1'b0, "R6 unexpected data symbol", 32'(s), 32'h0);
        end else begin
          e = expQ.pop_front();
          chk(s == e, "R2/R3/R4/R5/R10 data symbol", 32'(s), 32'(e));
        end
        frameCnt = (frameCnt + 1) % FSYM;
      end
      prev = s;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R6 run did not finish actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sym == SK, "R1 reset symbol", 32'(sym), 32'(SK));
    chk(overrun == 1'b0, "R1 reset overrun", 32'(overrun), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(sym == SJ, "R1 idle first J", 32'(sym), 32'(SJ));
    @(negedge clk);
    chk(sym == SK, "R1 idle then K", 32'(sym), 32'(SK));
    repeat (5) @(negedge clk);

    // all channels on, block flag set
    sendFrame(1'b1, '1, rndPay(), 1'b1);
    drain();
    // mixed on/off, extreme payloads (R5)
    sendFrame(1'b0, 4'b0101, {NCH*PW{1'b1}}, 1'b1);
    drain();
    // all off (R5)
    sendFrame(1'b1, '0, rndPay(), 1'b1);
    drain();
    sendFrame(1'b0, 4'b1010, rndPay(), 1'b1);
    drain();
    chk(overrun == 1'b0, "R9 no overrun on spaced frames", 32'(overrun), 32'h0);

    // R9: second strobe while the first is pending, then one mid-frame
    sendFrame(1'b0, '1, rndPay(), 1'b1);
    sendFrame(1'b1, '1, rndPay(), 1'b0);
    chk(overrun == 1'b1, "R9 overrun set while pending", 32'(overrun), 32'h1);
    repeat (8) @(negedge clk);
    sendFrame(1'b1, 4'b0011, rndPay(), 1'b0);
    drain();
    chk(overrun == 1'b1, "R9 overrun sticky", 32'(overrun), 32'h1);
    sendFrame(1'b1, 4'b0110, rndPay(), 1'b1);
    drain();
    chk(overrun == 1'b1, "R9 overrun still set, frame accepted", 32'(overrun), 32'h1);
    chk(expQ.size() == 0, "R6 all expected symbols sent", 32'(expQ.size()), 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule